// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block is the reset controller of a small microcontroller. It takes three reset requests: an active-low external reset pin, a one-cycle software reset strobe, and a watchdog overflow. Any of them starts an internal reset sequence that lasts a fixed number of clock cycles, `SEQ_CYCLES`. After power-on the sequence lasts twice as long. A request that arrives while a sequence is running starts the count again.

A watchdog request does not cut a running external bus cycle short. The block first parks in a wait state until the bus cycle ends. If the cycle uses READY, the bus controller reports the end of the wait states, and the block samples READY at that moment. READY low lets the cycle complete. READY high aborts the cycle, and the block raises a one-cycle abort pulse. The external pin and the software strobe do not wait.

When a sequence ends, the block latches a configuration word from a parallel port. The bus-enable outputs follow that word immediately. The reset output pin stays low, and the general-purpose pins are held as inputs, until software pulses end-of-initialization. A small code records which source caused the last reset.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n` is low, `rst_int`=1, `rst_out_n`=0, `gpio_in_force`=1, `bus_en`=0 and `cause`=0 (power-on). After `por_n` rises, `rst_int` stays high for exactly 2·SEQ_CYCLES clock cycles, counting the cycle in which it rises.
- R2: A one-cycle `sw_rst` pulse makes `rst_int` high from the next edge for exactly SEQ_CYCLES cycles, and sets `cause` to 2.
- R3: `ext_rst_n` passes through a two-flop synchronizer. While it is held low, the sequence keeps restarting. After it is released, `rst_int` stays high for SEQ_CYCLES+1 more sampled cycles. `cause` becomes 1.
- R4: A `wdt_ovf` pulse with `bus_busy`=0 gives a SEQ_CYCLES-long sequence and sets `cause` to 3. The pulse is ignored while `wdt_dis`=1 or `boot_mode`=1.
- R5: A watchdog request while `bus_busy`=1 and `bus_uses_rdy`=0 keeps `rst_int` low until `bus_busy` falls. The sequence then starts at the next edge.
- R6: In the watchdog wait with `bus_uses_rdy`=1, when `bus_ws_done`=1 the block samples READY. With `bus_rdy_n`=1, `bus_abort` is high in that same cycle. With `bus_rdy_n`=0, `bus_abort` stays low. In both cases the sequence starts at the next edge.
- R7: A software or external request during the watchdog bus wait starts the sequence at once, and the cause reflects that source.
- R8: A request during a running sequence reloads the counter, so the sequence ends SEQ_CYCLES cycles after the last request.
- R9: `rst_out_n` stays low after a sequence ends until an `einit` pulse. An `einit` pulse during a sequence has no effect. `gpio_in_force` is high exactly while `rst_out_n` is low.
- R10: `cfg_latched` takes the value of `port_cfg` in the last sequence cycle and holds it while the block runs. `bus_en` is 0 during a sequence and equals `cfg_latched` otherwise.
- R11: `cause` keeps its value until the next sequence starts. Ignored watchdog requests do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sw_rst | input | 1 | Software reset strobe |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| wdt_dis | input | 1 | Watchdog disabled by initialization |
| boot_mode | input | 1 | Bootstrap-loader mode active |
| bus_busy | input | 1 | External bus cycle in progress |
| bus_uses_rdy | input | 1 | Running bus cycle uses READY |
| bus_ws_done | input | 1 | Programmed wait states have elapsed |
| bus_rdy_n | input | 1 | READY, active low |
| einit | input | 1 | End-of-initialization pulse |
| port_cfg | input | CFG_W | Parallel port configuration inputs |
| rst_int | output | 1 | Internal reset, active high |
| rst_out_n | output | 1 | Reset output pin, active low |
| bus_abort | output | 1 | Bus cycle abort pulse |
| cfg_latched | output | CFG_W | Latched configuration word |
| bus_en | output | CFG_W | Bus control enables |
| gpio_in_force | output | 1 | Forces general-purpose pins to input mode |
| cause | output | 2 | Last reset source: 0 power-on, 1 pin, 2 software, 3 watchdog |

## Verification
A wrong count in the sequence timer shows up directly in the length of `rst_int`. The bench measures that length to the cycle in every mode, so an off-by-one shows within one sequence. A controller stuck in the bus wait shows as `rst_int` rising too early or too late around `bus_busy` and `bus_ws_done`, and as a wrong `bus_abort` in the sampling cycle. A bad latch or bad init flag shows at the first sample after a sequence ends, on `cfg_latched`, `bus_en`, `rst_out_n` or `cause`.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_WAIT = 2'd1, ST_SEQ = 2'd2} seq_state_e;
  typedef enum logic [1:0] {C_POR = 2'd0, C_PIN = 2'd1, C_SW = 2'd2, C_WDT = 2'd3} rst_cause_e;

  // length of a reset sequence: power-on runs two back to back
  function automatic int unsigned seq_len(int unsigned n, bit por);
    return por ? 2 * n : n;
  endfunction
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 (
  input  logic clk,
  input  logic por_n,
  input  logic d_async,
  output logic q
);
  logic s1, s2;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= d_async;
      s2 <= s1;
    end
  end
  assign q = s2;
endmodule

// File: rtl/rst_bus_gate.sv
module rst_bus_gate (
  input  logic in_wait,
  input  logic bus_busy,
  input  logic bus_uses_rdy,
  input  logic bus_ws_done,
  input  logic bus_rdy_n,
  output logic wait_exit,
  output logic abort
);
  logic rdy_sample;
  assign rdy_sample = in_wait && bus_busy && bus_uses_rdy && bus_ws_done;
  assign abort      = rdy_sample && bus_rdy_n;
  assign wait_exit  = in_wait && (!bus_busy || rdy_sample);
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int unsigned SEQ_CYCLES = 518
) (
  input  logic clk,
  input  logic por_n,
  input  logic load,
  input  logic in_seq,
  output logic expire
);
  localparam int unsigned POR_LEN = rst_seq_pkg::seq_len(SEQ_CYCLES, 1'b1);
  localparam int unsigned SEQ_LEN = rst_seq_pkg::seq_len(SEQ_CYCLES, 1'b0);
  localparam int unsigned CW      = $clog2(POR_LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  cnt <= CW'(POR_LEN);
    else if (load)               cnt <= CW'(SEQ_LEN);
    else if (in_seq && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expire = in_seq && !load && (cnt == CW'(1));

  p_cnt_live_r8: assert property (@(posedge clk) disable iff (!por_n)
    in_seq |-> cnt != 0);
  p_load_full_r8: assert property (@(posedge clk) disable iff (!por_n)
    load |=> cnt == CW'(SEQ_LEN));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int unsigned SEQ_CYCLES = 518,
  parameter int unsigned CFG_W      = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             sw_rst,
  input  logic             wdt_ovf,
  input  logic             wdt_dis,
  input  logic             boot_mode,
  input  logic             bus_busy,
  input  logic             bus_uses_rdy,
  input  logic             bus_ws_done,
  input  logic             bus_rdy_n,
  input  logic             einit,
  input  logic [CFG_W-1:0] port_cfg,
  output logic             rst_int,
  output logic             rst_out_n,
  output logic             bus_abort,
  output logic [CFG_W-1:0] cfg_latched,
  output logic [CFG_W-1:0] bus_en,
  output logic             gpio_in_force,
  output logic [1:0]       cause
);
  import rst_seq_pkg::*;

  seq_state_e state;
  rst_cause_e cause_q;
  logic ext_sync, hw_req, wd_req, wait_exit, start_seq, go_wait, expire, init_done;
  logic [CFG_W-1:0] cfg_q;

  rst_sync2 u_sync (.clk(clk), .por_n(por_n), .d_async(ext_rst_n), .q(ext_sync));

  rst_bus_gate u_gate (
    .in_wait(state == ST_WAIT), .bus_busy(bus_busy), .bus_uses_rdy(bus_uses_rdy),
    .bus_ws_done(bus_ws_done), .bus_rdy_n(bus_rdy_n),
    .wait_exit(wait_exit), .abort(bus_abort));

  rst_seq_timer #(.SEQ_CYCLES(SEQ_CYCLES)) u_timer (
    .clk(clk), .por_n(por_n), .load(start_seq), .in_seq(state == ST_SEQ), .expire(expire));

  // request decoding
  assign hw_req    = !ext_sync;
  assign wd_req    = wdt_ovf && !wdt_dis && !boot_mode;
  assign start_seq = hw_req || sw_rst
                  || (wd_req && (state == ST_SEQ || (state == ST_RUN && !bus_busy)))
                  || wait_exit;
  assign go_wait   = (state == ST_RUN) && wd_req && bus_busy && !hw_req && !sw_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state     <= ST_SEQ;
      cause_q   <= C_POR;
      cfg_q     <= '0;
      init_done <= 1'b0;
    end else begin
      if (start_seq) begin
        state     <= ST_SEQ;
        cause_q   <= hw_req ? C_PIN : (sw_rst ? C_SW : C_WDT);
        init_done <= 1'b0;
      end else if (go_wait) begin
        state <= ST_WAIT;
      end else if (expire) begin
        state <= ST_RUN;
        cfg_q <= port_cfg;
      end else if (einit && state == ST_RUN) begin
        init_done <= 1'b1;
      end
    end
  end

  assign rst_int       = (state == ST_SEQ);
  assign rst_out_n     = init_done;
  assign gpio_in_force = !init_done;
  assign cfg_latched   = cfg_q;
  assign bus_en        = rst_int ? '0 : cfg_q;
  assign cause         = cause_q;

  p_out_low_in_seq_r9: assert property (@(posedge clk) disable iff (!por_n)
    rst_int |-> !rst_out_n);
  p_out_rise_einit_r9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> $past(einit));
  p_abort_starts_r6: assert property (@(posedge clk) disable iff (!por_n)
    bus_abort |=> rst_int);
  p_wait_from_wdt_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(state == ST_WAIT) |-> $past(wdt_ovf) && $past(bus_busy));
  p_boot_ignore_r4: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_RUN && wdt_ovf && boot_mode && !hw_req && !sw_rst) |=> !rst_int);
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_int && $past(!rst_int)) |-> $stable(cfg_latched));
endmodule

// File: tb/rst_sequencer_test.sv
module rst_sequencer_test;
  localparam int N = 6;
  localparam int W = 4;

  logic clk = 0;
  logic por_n = 0, ext_rst_n = 1, sw_rst = 0, wdt_ovf = 0, wdt_dis = 0, boot_mode = 0;
  logic bus_busy = 0, bus_uses_rdy = 0, bus_ws_done = 0, bus_rdy_n = 1, einit = 0;
  logic [W-1:0] port_cfg = '0;
  logic rst_int, rst_out_n, bus_abort, gpio_in_force;
  logic [W-1:0] cfg_latched, bus_en;
  logic [1:0] cause;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rst_sequencer #(.SEQ_CYCLES(N), .CFG_W(W)) uut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sw_rst(sw_rst), .wdt_ovf(wdt_ovf),
    .wdt_dis(wdt_dis), .boot_mode(boot_mode), .bus_busy(bus_busy), .bus_uses_rdy(bus_uses_rdy),
    .bus_ws_done(bus_ws_done), .bus_rdy_n(bus_rdy_n), .einit(einit), .port_cfg(port_cfg),
    .rst_int(rst_int), .rst_out_n(rst_out_n), .bus_abort(bus_abort), .cfg_latched(cfg_latched),
    .bus_en(bus_en), .gpio_in_force(gpio_in_force), .cause(cause));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts sampled cycles with rst_int high, starting at the current negedge
  task automatic measure(output int len);
    len = 0;
    while (rst_int && len < 100) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_sw();
    sw_rst = 1; @(negedge clk); sw_rst = 0;
  endtask

  task automatic pulse_wdt();
    wdt_ovf = 1; @(negedge clk); wdt_ovf = 0;
  endtask

  task automatic do_einit();
    einit = 1; @(negedge clk); einit = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run finished)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int len;
    port_cfg = 4'hA;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rst_int in reset", rst_int, 1);
    chk("R1 rst_out_n in reset", rst_out_n, 0);
    chk("R1 gpio_in_force in reset", gpio_in_force, 1);
    chk("R1 bus_en in reset", bus_en, 0);
    chk("R1 cause in reset", cause, 0);
    por_n = 1;
    measure(len);
    chk("R1 power-on length", len, 2 * N);
    chk("R10 cfg after power-on", cfg_latched, 4'hA);
    chk("R10 bus_en follows cfg", bus_en, 4'hA);
    chk("R9 rst_out_n held after seq", rst_out_n, 0);
    do_einit();
    chk("R9 rst_out_n after einit", rst_out_n, 1);
    chk("R9 gpio released", gpio_in_force, 0);

    // R2 software reset, several config words
    for (int v = 1; v < 16; v += 5) begin
      port_cfg = W'(v);
      pulse_sw();
      chk("R10 bus_en zero in seq", bus_en, 0);
      chk("R9 rst_out_n low in seq", rst_out_n, 0);
      measure(len);
      chk("R2 sw length", len, N);
      chk("R2 cause sw", cause, 2);
      chk("R10 cfg latched", cfg_latched, v);
      do_einit();
    end

    // R8 restart inside a sequence, einit ignored there
    for (int k = 1; k < N; k++) begin
      pulse_sw();
      repeat (k - 1) @(negedge clk);
      einit = 1; @(negedge clk); einit = 0;
      port_cfg = 4'h3;
      pulse_sw();
      measure(len);
      chk("R8 restarted length", len, N);
      chk("R9 einit in seq ignored", rst_out_n, 0);
      chk("R10 cfg last cycle", cfg_latched, 3);
      port_cfg = 4'h9;
      repeat (3) @(negedge clk);
      chk("R10 cfg held while running", cfg_latched, 3);
      do_einit();
    end

    // R3 external pin
    ext_rst_n = 0;
    repeat (4) @(negedge clk);
    chk("R3 pin reset active", rst_int, 1);
    ext_rst_n = 1;
    @(negedge clk);
    measure(len);
    chk("R3 pin length after release", len, N + 1);
    chk("R3 cause pin", cause, 1);
    do_einit();

    // R4 ignored watchdog, R11 cause kept
    wdt_dis = 1; pulse_wdt(); wdt_dis = 0;
    repeat (2) @(negedge clk);
    chk("R4 wdt_dis ignores", rst_int, 0);
    boot_mode = 1; pulse_wdt(); boot_mode = 0;
    repeat (2) @(negedge clk);
    chk("R4 boot_mode ignores", rst_int, 0);
    chk("R4 rst_out_n untouched", rst_out_n, 1);
    chk("R11 cause kept", cause, 1);

    // R4 watchdog with bus idle
    pulse_wdt();
    measure(len);
    chk("R4 wdt length", len, N);
    chk("R4 cause wdt", cause, 3);
    do_einit();

    // R5 wait for bus cycle without READY
    for (int w = 0; w < 4; w++) begin
      bus_busy = 1; bus_uses_rdy = 0;
      pulse_wdt();
      for (int i = 0; i < w + 1; i++) begin
        chk("R5 held during bus cycle", rst_int, 0);
        chk("R6 no abort without READY", bus_abort, 0);
        @(negedge clk);
      end
      bus_busy = 0;
      @(negedge clk);
      measure(len);
      chk("R5 wdt length after bus", len, N);
      do_einit();
    end

    // R6 READY sampled after wait states, both levels
    for (int r = 0; r < 2; r++) begin
      bus_busy = 1; bus_uses_rdy = 1; bus_ws_done = 0;
      pulse_wdt();
      @(negedge clk);
      chk("R6 waiting for wait states", rst_int, 0);
      bus_ws_done = 1; bus_rdy_n = r[0];
      #1;
      chk("R6 abort pulse level", bus_abort, r);
      @(negedge clk);
      bus_ws_done = 0; bus_busy = 0; bus_rdy_n = 1;
      chk("R6 abort gone", bus_abort, 0);
      measure(len);
      chk("R6 sequence length", len, N);
      do_einit();
    end

    // R7 software request during bus wait
    bus_busy = 1; bus_uses_rdy = 0;
    pulse_wdt();
    @(negedge clk);
    chk("R7 in bus wait", rst_int, 0);
    pulse_sw();
    measure(len);
    chk("R7 sw during wait length", len, N);
    chk("R7 cause sw", cause, 2);
    bus_busy = 0;
    repeat (3) @(negedge clk);
    chk("R11 cause after bus freed", cause, 2);
    chk("R7 no extra seq", rst_int, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule